// File: doc/BRIEF.md
# NAND Read/Write Timing Count Calculator

This block turns a NAND interface speed grade (timing mode 0 to 5) into the clock-count settings a flash controller needs for its strobe and gap timers. A host raises `start` for one cycle with the wanted mode. The block then reads the nanosecond limits of that grade from an internal table and derives each count for a controller clock whose period is the parameter `CLK_NS`. The iterative margin rules run one step per clock. When every count is final, `done` is high for one cycle, and the counts stay on the outputs until the next accepted start.

The sequencer has eight named states. IDLE waits for `start` and latches the clamped mode (IDLE to LOAD). LOAD takes the base ceilings of every limit (to STRETCH). STRETCH widens the strobe low time so that a full strobe cycle covers the read-cycle limit (to FLOOR). FLOOR lifts the low count so that the low-plus-high sum reaches `SUM_FLOOR` (to WINDOW). WINDOW adds one to the low count per clock until the data-valid window is large enough (stays there, then to ACCESS). ACCESS adds one to the access count per clock until its margin holds (stays, then to CSEL). CSEL adds one to the chip-select count per clock until the enable-access limit is met (stays, then to FINISH). FINISH drives `done` (FINISH to IDLE).

Top module: `nand_tcalc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every count output is 0.
- R2: A mode of 6 or 7 gives exactly the same counts as mode 5.
- R3: The strobe high count starts as ceil(tREH/P). When that count times P is below tREH+2, it is one higher.
- R4: If (low+high)·P is below tRC, the low count grows by ceil((tRC−(low+high)·P)/P). After that the low count is raised so that low+high is at least `SUM_FLOOR`. The low count starts as ceil(tRP/P).
- R5: The low count then rises by one per step until min(low·P+tRHOH, (low+high)·P+tRLOH) − tREA ≥ 8.
- R6: The access count is the smallest value that is at least ceil(tREA/P) and satisfies count·P − tREA ≥ 3.
- R7: The address-to-data, read-to-write, read-to-read and write-to-read counts are ceil(tADL/P), ceil(tRHW/P), ceil(tRHZ/P) and ceil(tWHR/P). A difference that would be negative counts as zero.
- R8: The chip-select count starts at max(1, ceil(max(0, tCS−tRP)/P)). It is then raised until count·P + tREA ≥ tCEA.
- R9: `busy` rises the cycle after an accepted start. `done` is a single-cycle pulse at the end of a run. The count outputs do not change while `busy` is low.
- R10: A `start` given while `busy` is high is ignored, and the running computation keeps its original mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| mode | input | 3 | Timing mode, values above 5 act as 5 |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| strobe_lo | output | CNT_W | Read/write enable low count |
| strobe_hi | output | CNT_W | Read/write enable high count |
| access_cnt | output | CNT_W | Data access delay count |
| addr_data_cnt | output | CNT_W | Address-to-data gap count |
| rd_wr_cnt | output | CNT_W | Read-to-write gap count |
| rd_rd_cnt | output | CNT_W | Read-to-read gap count |
| wr_rd_cnt | output | CNT_W | Write-to-read gap count |
| cs_setup_cnt | output | CNT_W | Chip-select setup count |

## Verification
The bench builds the block with `CLK_NS` = 5 and `SUM_FLOOR` = 6. With a 5 ns period, the slow grades need several access and chip-select steps: mode 0 climbs from 8 to 9 and from 4 to 12. The read-cycle stretch and the high-margin bump also both fire in mode 0. A floor of 6 is above the natural mode-5 sum of 4, so the minimum-sum rule visibly lifts the low count from 2 to 4. Random modes, including the out-of-range codes, are compared with a bench reference model.

// File: rtl/nand_tcalc_pkg.sv
package nand_tcalc_pkg;
    localparam int LIM_W  = 8;
    localparam int CALC_W = 16;
    localparam int MODE_W = 3;
    localparam int MODE_MAX = 5;

    typedef logic [CALC_W-1:0] calc_t;

    typedef struct packed {
        logic [LIM_W-1:0] trea;
        logic [LIM_W-1:0] trp;
        logic [LIM_W-1:0] treh;
        logic [LIM_W-1:0] trc;
        logic [LIM_W-1:0] trhoh;
        logic [LIM_W-1:0] trloh;
        logic [LIM_W-1:0] tcea;
        logic [LIM_W-1:0] tadl;
        logic [LIM_W-1:0] trhw;
        logic [LIM_W-1:0] trhz;
        logic [LIM_W-1:0] twhr;
        logic [LIM_W-1:0] tcs;
    } lim_t;

    function automatic calc_t ceil_div(input calc_t num, input calc_t den);
        return (num + den - calc_t'(1)) / den;
    endfunction
endpackage

// File: rtl/nand_tcalc_table.sv
module nand_tcalc_table
    import nand_tcalc_pkg::*;
(
    input  logic [MODE_W-1:0] sel,
    output lim_t              lim
);
    // fields: trea trp treh trc trhoh trloh tcea tadl trhw trhz twhr tcs
    always_comb begin
        unique case (sel)
            3'd0:    lim = '{8'd40, 8'd50, 8'd30, 8'd100, 8'd0,  8'd0, 8'd100, 8'd200, 8'd200, 8'd200, 8'd120, 8'd70};
            3'd1:    lim = '{8'd30, 8'd25, 8'd15, 8'd50,  8'd15, 8'd0, 8'd45,  8'd100, 8'd100, 8'd100, 8'd80,  8'd35};
            3'd2:    lim = '{8'd25, 8'd17, 8'd15, 8'd35,  8'd15, 8'd0, 8'd30,  8'd100, 8'd100, 8'd100, 8'd80,  8'd25};
            3'd3:    lim = '{8'd20, 8'd15, 8'd10, 8'd30,  8'd15, 8'd0, 8'd25,  8'd100, 8'd100, 8'd100, 8'd60,  8'd25};
            3'd4:    lim = '{8'd20, 8'd12, 8'd10, 8'd25,  8'd15, 8'd5, 8'd25,  8'd70,  8'd100, 8'd100, 8'd60,  8'd20};
            default: lim = '{8'd16, 8'd10, 8'd7,  8'd20,  8'd15, 8'd5, 8'd25,  8'd70,  8'd100, 8'd100, 8'd60,  8'd15};
        endcase
    end
endmodule

// File: rtl/nand_tcalc_engine.sv
module nand_tcalc_engine
    import nand_tcalc_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int CNT_W      = 8,
    parameter int SUM_FLOOR  = 4,
    parameter int WIN_MIN    = 8,
    parameter int ACC_MARGIN = 3,
    parameter int HI_MARGIN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  lim_t              lim,
    output logic [MODE_W-1:0] mode_q,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  lo_q,
    output logic [CNT_W-1:0]  hi_q,
    output logic [CNT_W-1:0]  acc_q,
    output logic [CNT_W-1:0]  a2d_q,
    output logic [CNT_W-1:0]  r2w_q,
    output logic [CNT_W-1:0]  r2r_q,
    output logic [CNT_W-1:0]  w2r_q,
    output logic [CNT_W-1:0]  cs_q
);
    typedef logic [CNT_W-1:0] cnt_t;
    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_STRETCH, S_FLOOR, S_WINDOW, S_ACCESS, S_CSEL, S_FINISH
    } state_t;

    localparam calc_t P_W    = calc_t'(CLK_NS);
    localparam calc_t FLOOR  = calc_t'(SUM_FLOOR);
    localparam calc_t WIN_W  = calc_t'(WIN_MIN);
    localparam calc_t ACC_W  = calc_t'(ACC_MARGIN);
    localparam calc_t HIM_W  = calc_t'(HI_MARGIN);

    state_t state, state_nx;

    calc_t trea_w, trp_w, treh_w, trc_w, trhoh_w, trloh_w, tcea_w, tcs_w;
    calc_t lo_w, hi_w, sum_w, lo_ns, sum_ns, acc_ns, cs_ns;
    calc_t c_treh, hi_base, cs_raw, cs_base, short_ns, rhoh_ns, rloh_ns, dinv;
    logic  win_ok, acc_ok, cs_ok;

    always_comb begin
        trea_w  = calc_t'(lim.trea);
        trp_w   = calc_t'(lim.trp);
        treh_w  = calc_t'(lim.treh);
        trc_w   = calc_t'(lim.trc);
        trhoh_w = calc_t'(lim.trhoh);
        trloh_w = calc_t'(lim.trloh);
        tcea_w  = calc_t'(lim.tcea);
        tcs_w   = calc_t'(lim.tcs);
        lo_w    = calc_t'(lo_q);
        hi_w    = calc_t'(hi_q);
        sum_w   = lo_w + hi_w;
        lo_ns   = lo_w * P_W;
        sum_ns  = sum_w * P_W;
        acc_ns  = calc_t'(acc_q) * P_W;
        cs_ns   = calc_t'(cs_q) * P_W;
        c_treh  = ceil_div(treh_w, P_W);
        hi_base = (c_treh * P_W < treh_w + HIM_W) ? c_treh + calc_t'(1) : c_treh;
        cs_raw  = (tcs_w > trp_w) ? ceil_div(tcs_w - trp_w, P_W) : '0;
        cs_base = (cs_raw == '0) ? calc_t'(1) : cs_raw;
        short_ns = (sum_ns < trc_w) ? trc_w - sum_ns : '0;
        rhoh_ns = lo_ns + trhoh_w;
        rloh_ns = sum_ns + trloh_w;
        dinv    = (rhoh_ns < rloh_ns) ? rhoh_ns : rloh_ns;
        win_ok  = dinv >= trea_w + WIN_W;
        acc_ok  = acc_ns >= trea_w + ACC_W;
        cs_ok   = (tcea_w == '0) || (cs_ns + trea_w >= tcea_w);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_LOAD;
            S_LOAD:    state_nx = S_STRETCH;
            S_STRETCH: state_nx = S_FLOOR;
            S_FLOOR:   state_nx = S_WINDOW;
            S_WINDOW:  if (win_ok) state_nx = S_ACCESS;
            S_ACCESS:  if (acc_ok) state_nx = S_CSEL;
            S_CSEL:    if (cs_ok)  state_nx = S_FINISH;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH);

    // datapath / output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            acc_q  <= '0;
            a2d_q  <= '0;
            r2w_q  <= '0;
            r2r_q  <= '0;
            w2r_q  <= '0;
            cs_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start)
                    mode_q <= (mode > MODE_W'(MODE_MAX)) ? MODE_W'(MODE_MAX) : mode;
                S_LOAD: begin
                    lo_q  <= cnt_t'(ceil_div(trp_w, P_W));
                    hi_q  <= cnt_t'(hi_base);
                    acc_q <= cnt_t'(ceil_div(trea_w, P_W));
                    a2d_q <= cnt_t'(ceil_div(calc_t'(lim.tadl), P_W));
                    r2w_q <= cnt_t'(ceil_div(calc_t'(lim.trhw), P_W));
                    r2r_q <= cnt_t'(ceil_div(calc_t'(lim.trhz), P_W));
                    w2r_q <= cnt_t'(ceil_div(calc_t'(lim.twhr), P_W));
                    cs_q  <= cnt_t'(cs_base);
                end
                S_STRETCH: lo_q <= cnt_t'(lo_w + ceil_div(short_ns, P_W));
                S_FLOOR:   if (sum_w < FLOOR) lo_q <= cnt_t'(FLOOR - hi_w);
                S_WINDOW:  if (!win_ok) lo_q <= lo_q + cnt_t'(1);
                S_ACCESS:  if (!acc_ok) acc_q <= acc_q + cnt_t'(1);
                S_CSEL:    if (!cs_ok)  cs_q <= cs_q + cnt_t'(1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nand_tcalc.sv
module nand_tcalc
    import nand_tcalc_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int CNT_W     = 8,
    parameter int SUM_FLOOR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  strobe_lo,
    output logic [CNT_W-1:0]  strobe_hi,
    output logic [CNT_W-1:0]  access_cnt,
    output logic [CNT_W-1:0]  addr_data_cnt,
    output logic [CNT_W-1:0]  rd_wr_cnt,
    output logic [CNT_W-1:0]  rd_rd_cnt,
    output logic [CNT_W-1:0]  wr_rd_cnt,
    output logic [CNT_W-1:0]  cs_setup_cnt
);
    lim_t              lim;
    logic [MODE_W-1:0] mode_q;

    nand_tcalc_table u_table (
        .sel (mode_q),
        .lim (lim)
    );

    nand_tcalc_engine #(
        .CLK_NS    (CLK_NS),
        .CNT_W     (CNT_W),
        .SUM_FLOOR (SUM_FLOOR)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .lim    (lim),
        .mode_q (mode_q),
        .busy   (busy),
        .done   (done),
        .lo_q   (strobe_lo),
        .hi_q   (strobe_hi),
        .acc_q  (access_cnt),
        .a2d_q  (addr_data_cnt),
        .r2w_q  (rd_wr_cnt),
        .r2r_q  (rd_rd_cnt),
        .w2r_q  (wr_rd_cnt),
        .cs_q   (cs_setup_cnt)
    );
endmodule

// File: rtl/nand_tcalc_chk.sv
module nand_tcalc_chk #(
    parameter int CNT_W     = 8,
    parameter int SUM_FLOOR = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] strobe_lo,
    input logic [CNT_W-1:0] strobe_hi,
    input logic [CNT_W-1:0] access_cnt,
    input logic [CNT_W-1:0] cs_setup_cnt
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(strobe_lo) && $stable(strobe_hi) &&
                   $stable(access_cnt) && $stable(cs_setup_cnt)));

    p_cs_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_setup_cnt != '0));

    p_sum_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({1'b0, strobe_lo} + {1'b0, strobe_hi} >= (CNT_W+1)'(SUM_FLOOR)));
endmodule

bind nand_tcalc nand_tcalc_chk #(.CNT_W(CNT_W), .SUM_FLOOR(SUM_FLOOR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .strobe_lo    (strobe_lo),
    .strobe_hi    (strobe_hi),
    .access_cnt   (access_cnt),
    .cs_setup_cnt (cs_setup_cnt)
);

// File: tb/test_nand_tcalc.sv
`timescale 1ns/1ps
module test_nand_tcalc;
    localparam int P     = 5;
    localparam int FLOOR = 6;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode = '0;
    logic busy, done;
    logic [CW-1:0] s_lo, s_hi, acc, a2d, r2w, r2r, w2r, cs;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nand_tcalc #(.CLK_NS(P), .CNT_W(CW), .SUM_FLOOR(FLOOR)) i_nand_tcalc (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .busy(busy), .done(done),
        .strobe_lo(s_lo), .strobe_hi(s_hi), .access_cnt(acc),
        .addr_data_cnt(a2d), .rd_wr_cnt(r2w), .rd_rd_cnt(r2r),
        .wr_rd_cnt(w2r), .cs_setup_cnt(cs)
    );

    int k_rea[6]  = '{40, 30, 25, 20, 20, 16};
    int k_rp[6]   = '{50, 25, 17, 15, 12, 10};
    int k_reh[6]  = '{30, 15, 15, 10, 10, 7};
    int k_rc[6]   = '{100, 50, 35, 30, 25, 20};
    int k_rhoh[6] = '{0, 15, 15, 15, 15, 15};
    int k_rloh[6] = '{0, 0, 0, 0, 5, 5};
    int k_cea[6]  = '{100, 45, 30, 25, 25, 25};
    int k_adl[6]  = '{200, 100, 100, 100, 70, 70};
    int k_rhw[6]  = '{200, 100, 100, 100, 100, 100};
    int k_rhz[6]  = '{200, 100, 100, 100, 100, 100};
    int k_whr[6]  = '{120, 80, 80, 60, 60, 60};
    int k_cs[6]   = '{70, 35, 25, 25, 20, 15};

    int e_lo, e_hi, e_acc, e_a2d, e_r2w, e_r2r, e_w2r, e_cs;

    function automatic int cdiv(int a);
        return (a <= 0) ? 0 : (a + P - 1) / P;
    endfunction

    task automatic model(input int m_in);
        int m, win, rh, rl;
        m = (m_in > 5) ? 5 : m_in;
        e_lo = cdiv(k_rp[m]);
        e_hi = cdiv(k_reh[m]);
        if (e_hi * P < k_reh[m] + 2) e_hi++;
        if ((e_lo + e_hi) * P < k_rc[m]) e_lo += cdiv(k_rc[m] - (e_lo + e_hi) * P);
        if (e_lo + e_hi < FLOOR) e_lo = FLOOR - e_hi;
        do begin
            rh = e_lo * P + k_rhoh[m];
            rl = (e_lo + e_hi) * P + k_rloh[m];
            win = ((rh < rl) ? rh : rl) - k_rea[m];
            if (win < 8) e_lo++;
        end while (win < 8);
        e_acc = cdiv(k_rea[m]);
        while (e_acc * P - k_rea[m] < 3) e_acc++;
        e_a2d = cdiv(k_adl[m]);
        e_r2w = cdiv(k_rhw[m]);
        e_r2r = cdiv(k_rhz[m]);
        e_w2r = cdiv(k_whr[m]);
        e_cs = cdiv(k_cs[m] - k_rp[m]);
        if (e_cs == 0) e_cs = 1;
        while (e_cs * P + k_rea[m] < k_cea[m]) e_cs++;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic kick(input int m);
        @(negedge clk);
        start = 1'b1;
        mode = 3'(m);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(seen, "R9 done seen (watchdog)", int'(seen), 1);
    endtask

    task automatic check_all(input string tag);
        chk(int'(s_hi) == e_hi, {tag, " R3 strobe_hi"}, int'(s_hi), e_hi);
        chk(int'(s_lo) == e_lo, {tag, " R5 strobe_lo"}, int'(s_lo), e_lo);
        chk(int'(acc) == e_acc, {tag, " R6 access"}, int'(acc), e_acc);
        chk(int'(a2d) == e_a2d && int'(r2w) == e_r2w && int'(r2r) == e_r2r && int'(w2r) == e_w2r,
            {tag, " R7 gaps a2d"}, int'(a2d), e_a2d);
        chk(int'(cs) == e_cs, {tag, " R8 cs_setup"}, int'(cs), e_cs);
    endtask

    task automatic run(input int m, input string tag);
        bit seen;
        model(m);
        kick(m);
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        wait_done(seen);
        if (seen) begin
            check_all(tag);
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R9 done single pulse", int'(done), 0);
        end
    endtask

    initial begin
        bit seen;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'(busy), 0);
        chk(s_lo == '0 && s_hi == '0 && acc == '0 && cs == '0 && a2d == '0, "R1 reset counts", int'(s_lo), 0);
        rst_n = 1'b1;

        // directed: mode 0 hand values
        run(0, "mode0");
        chk(int'(s_lo) == 13 && int'(s_hi) == 7, "R4 stretch mode0 lo", int'(s_lo), 13);
        chk(int'(acc) == 9, "R6 mode0 access", int'(acc), 9);
        chk(int'(cs) == 12, "R8 mode0 cs", int'(cs), 12);
        chk(int'(a2d) == 40 && int'(w2r) == 24, "R7 mode0 a2d", int'(a2d), 40);

        // directed: mode 5, sum floor lifts lo from 2 to 4
        run(5, "mode5");
        chk(int'(s_lo) == 4 && int'(s_hi) == 2, "R4 floor mode5 lo", int'(s_lo), 4);
        chk(int'(cs) == 2 && int'(acc) == 4, "R8 mode5 cs", int'(cs), 2);

        // R2: out-of-range modes
        run(6, "mode6 R2");
        chk(int'(s_lo) == 4 && int'(cs) == 2 && int'(w2r) == 12, "R2 mode6 as mode5", int'(s_lo), 4);
        run(7, "mode7 R2");
        chk(int'(r2w) == 20 && int'(acc) == 4, "R2 mode7 as mode5", int'(r2w), 20);

        // R10: start while busy is ignored
        model(0);
        kick(0);
        @(negedge clk);
        start = 1'b1;
        mode = 3'd5;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        if (seen) check_all("R10 busy-start");
        chk(int'(cs) == 12, "R10 original mode kept", int'(cs), 12);

        // R9: outputs hold while idle even with mode toggling
        mode = 3'd3;
        repeat (5) @(negedge clk);
        chk(int'(cs) == 12 && busy == 1'b0, "R9 idle hold", int'(cs), 12);

        // random
        for (int r = 0; r < 40; r++) begin
            int m;
            int gap;
            m = int'($urandom_range(0, 7));
            gap = int'($urandom_range(0, 4));
            repeat (gap) @(negedge clk);
            run(m, $sformatf("rand m=%0d", m));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule